// File: doc/BRIEF.md
# Camera Link Packet Receiver

This block sits behind the lane-merging logic of a camera input path. It sees a single byte stream together with two framing strobes: one marks the start of a transmission burst, the other marks its end. Each burst carries exactly one packet. The receiver collects the four header bytes and repairs or rejects the header using its 6-bit error code. It then decides from the data type whether the packet is short or long. For a long packet it forwards exactly as many payload bytes as the word count says and compares the 16-bit footer with a CRC that it computes itself.

Payload length comes only from the header. Payload bytes are never scanned for synchronisation patterns, so they may take any value. When the packet is complete, or when the header cannot be repaired, the receiver ignores everything until the end-of-transmission strobe. Only after that strobe does it accept a new start.

Control is a five-state machine:
- `ST_IDLE` goes to `ST_HEADER` on `sot`.
- `ST_HEADER` goes to one of three states on the fourth header byte:
  - `ST_DRAIN` for an uncorrectable header or a short type;
  - `ST_FOOTER` for a long type whose word count is zero;
  - `ST_PAYLOAD` for any other long type.
- `ST_PAYLOAD` goes to `ST_FOOTER` on the last payload byte.
- `ST_FOOTER` goes to `ST_DRAIN` on the second footer byte.
- `ST_DRAIN` goes to `ST_IDLE` on `eot`.
- `ST_HEADER`, `ST_PAYLOAD` and `ST_FOOTER` also return to `ST_IDLE` on `eot`, and this counts as a truncation.

Top module: `camrx_pkt_rx`

## Requirements
- R1: After reset, every output strobe (`hdr_valid`, `pay_valid`, `pay_last`, `pkt_end`, `crc_err`, `trunc_err`) is low and the receiver waits for `sot`.
- R2: The four bytes accepted after `sot` form the header. Byte 0 is the identifier: virtual channel in bits [7:6], data type in bits [5:0]. Bytes 1 and 2 are the 16-bit word count (or short data field), low byte first. Byte 3 holds the ECC in bits [5:0]. `hdr_valid` pulses for one cycle, one cycle after the fourth byte is accepted, with the corrected fields.
- R3: A data type below 0x10 marks a short packet. `hdr_long` is 0, no payload or `pkt_end` follows, and the receiver waits for `eot`. Types 0x10 and above set `hdr_long` to 1.
- R4: The ECC covers 24 data bits: identifier bits 0..7, then word-count bits 8..23. Data bit i has a 6-bit column. The columns are the odd-weight values, taken in ascending order first among the weight-3 values and then among the weight-5 values: 7, 11, 13, 14, 19, 21, 22, 25, 26, 28, 35, 37, 38, 41, 42, 44, 49, 50, 52, 56, 31, 47, 55, 59. The ECC is the XOR of the columns of all set data bits. A single flipped bit, in the data or in the ECC, is repaired, and `hdr_corrected` is 1.
- R5: A syndrome that is neither zero, nor of weight one, nor equal to a column sets `hdr_fatal`. This covers every two-bit error. No payload and no `pkt_end` follow, and bytes are discarded until `eot`.
- R6: A long packet forwards exactly word-count payload bytes, of any value. Each byte appears on `pay_byte` with `pay_valid` one cycle after it is accepted. `pay_last` is set on the final byte.
- R7: The footer is the CRC of the payload, low byte first. The CRC uses polynomial x^16+x^12+x^5+1, is fed LSB first (reflected constant 0x8408) and is seeded with 0xFFFF, with no final inversion. `pkt_end` pulses one cycle after the second footer byte, and `crc_err` is 1 with it on a mismatch.
- R8: An `eot` in the header, payload or footer phase pulses `trunc_err` one cycle later and returns the receiver to idle.
- R9: After the footer, or after a short or fatal header, incoming bytes produce no output until `eot`.
- R10: A long packet with word count 0 goes straight to the footer phase, and its expected footer is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sot | input | 1 | Start-of-transmission strobe, taken only when idle |
| eot | input | 1 | End-of-transmission strobe |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_byte | input | 8 | Merged byte stream |
| hdr_valid | output | 1 | Header decoded (one-cycle pulse) |
| hdr_vc | output | 2 | Virtual channel |
| hdr_dt | output | 6 | Data type |
| hdr_wc | output | 16 | Word count or short data field |
| hdr_long | output | 1 | Packet carries payload and footer |
| hdr_corrected | output | 1 | A single-bit header error was repaired |
| hdr_fatal | output | 1 | Header error could not be repaired |
| pay_valid | output | 1 | Payload byte strobe |
| pay_byte | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte |
| pkt_end | output | 1 | Footer received and compared |
| crc_err | output | 1 | Footer mismatch, valid with `pkt_end` |
| trunc_err | output | 1 | Burst ended early |

## Verification
On every cycle, the assertions check the relations between the output strobes:
- `pay_last` only appears alongside `pay_valid`;
- a short or fatal header is never followed by payload;
- the footer strobe never coincides with payload or header strobes;
- the drain state is silent;
- a header is never both repaired and fatal.

Some behaviour can only be shown by the directed scenarios, which compare against an independently computed code and checksum:
- that the correct bit is flipped;
- that the CRC value matches;
- the exact byte count and order;
- that truncation and early bytes return the receiver to idle.

// File: rtl/camrx_pkg.sv
package camrx_pkg;

    localparam int HDR_DATA_W = 24;
    localparam int ECC_W      = 6;
    localparam int CRC_W      = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_PAYLOAD,
        ST_FOOTER,
        ST_DRAIN
    } rx_state_e;

    // Column of data bit idx: odd-weight codes, weight 3 ascending then weight 5.
    function automatic logic [ECC_W-1:0] ecc_column(input int idx);
        logic [ECC_W-1:0] col;
        int               n;
        col = '0;
        n   = 0;
        for (int w = 3; w <= 5; w += 2) begin
            for (int v = 0; v < (1 << ECC_W); v++) begin
                if ($countones(ECC_W'(v)) == w) begin
                    if (n == idx) col = ECC_W'(v);
                    n++;
                end
            end
        end
        return col;
    endfunction

    function automatic logic [ECC_W-1:0] ecc_parity(input logic [HDR_DATA_W-1:0] d);
        logic [ECC_W-1:0] p;
        p = '0;
        for (int i = 0; i < HDR_DATA_W; i++) begin
            if (d[i]) p = p ^ ecc_column(i);
        end
        return p;
    endfunction

    // One byte of a reflected CRC, LSB first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [7:0]       b,
                                                  input logic [CRC_W-1:0] poly_rev);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ b[i];
            r  = r >> 1;
            if (fb) r = r ^ poly_rev;
        end
        return r;
    endfunction

endpackage

// File: rtl/camrx_hdr_ecc.sv
module camrx_hdr_ecc
    import camrx_pkg::*;
(
    input  logic [HDR_DATA_W-1:0] data_in,
    input  logic [ECC_W-1:0]      ecc_in,
    output logic [HDR_DATA_W-1:0] data_out,
    output logic                  corrected,
    output logic                  fatal
);

    logic [ECC_W-1:0] syndrome;
    logic             hit;

    assign syndrome = ecc_in ^ ecc_parity(data_in);

    always_comb begin
        data_out  = data_in;
        corrected = 1'b0;
        fatal     = 1'b0;
        hit       = 1'b0;
        if (syndrome != '0) begin
            if ($countones(syndrome) == 1) begin
                corrected = 1'b1;
            end else begin
                for (int i = 0; i < HDR_DATA_W; i++) begin
                    if (syndrome == ecc_column(i)) begin
                        data_out[i] = ~data_in[i];
                        hit         = 1'b1;
                    end
                end
                corrected = hit;
                fatal     = ~hit;
            end
        end
    end

endmodule

// File: rtl/camrx_crc16.sv
module camrx_crc16
    import camrx_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY_REV = 16'h8408,
    parameter logic [CRC_W-1:0] SEED     = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [7:0]       din,
    output logic [CRC_W-1:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc <= SEED;
        else if (clear) crc <= SEED;
        else if (en)    crc <= crc_step(crc, din, POLY_REV);
    end

endmodule

// File: rtl/camrx_pkt_rx.sv
module camrx_pkt_rx
    import camrx_pkg::*;
#(
    parameter logic [5:0]       LONG_DT_MIN = 6'h10,
    parameter logic [CRC_W-1:0] CRC_POLY    = 16'h8408,
    parameter logic [CRC_W-1:0] CRC_SEED    = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sot,
    input  logic        eot,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        hdr_valid,
    output logic [1:0]  hdr_vc,
    output logic [5:0]  hdr_dt,
    output logic [15:0] hdr_wc,
    output logic        hdr_long,
    output logic        hdr_corrected,
    output logic        hdr_fatal,
    output logic        pay_valid,
    output logic [7:0]  pay_byte,
    output logic        pay_last,
    output logic        pkt_end,
    output logic        crc_err,
    output logic        trunc_err
);

    localparam logic [15:0] HDR_LAST  = 16'd3;
    localparam logic [15:0] FOOT_LAST = 16'd1;

    rx_state_e              state, state_nxt;
    logic [15:0]            cnt;
    logic [15:0]            wc_q;
    logic [HDR_DATA_W-1:0]  hdr_buf;
    logic [7:0]             foot_lo;
    logic [CRC_W-1:0]       crc_cur;

    logic [HDR_DATA_W-1:0]  dec_data;
    logic                   dec_corr, dec_fatal, dec_long;
    logic                   take, hdr_done, pay_take, foot_take, foot_done, in_burst;

    camrx_hdr_ecc u_ecc (
        .data_in   (hdr_buf),
        .ecc_in    (in_byte[ECC_W-1:0]),
        .data_out  (dec_data),
        .corrected (dec_corr),
        .fatal     (dec_fatal)
    );

    camrx_crc16 #(.POLY_REV(CRC_POLY), .SEED(CRC_SEED)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_IDLE),
        .en    (pay_take),
        .din   (in_byte),
        .crc   (crc_cur)
    );

    assign take      = in_valid && !eot;
    assign in_burst  = (state == ST_HEADER) || (state == ST_PAYLOAD) || (state == ST_FOOTER);
    assign hdr_done  = (state == ST_HEADER) && take && (cnt == HDR_LAST);
    assign pay_take  = (state == ST_PAYLOAD) && take;
    assign foot_take = (state == ST_FOOTER) && take;
    assign foot_done = foot_take && (cnt == FOOT_LAST);
    assign dec_long  = dec_data[5:0] >= LONG_DT_MIN;

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (sot) state_nxt = ST_HEADER;
            ST_HEADER: begin
                if (eot)                  state_nxt = ST_IDLE;
                else if (hdr_done) begin
                    if (dec_fatal || !dec_long)   state_nxt = ST_DRAIN;
                    else if (dec_data[23:8] == '0) state_nxt = ST_FOOTER;
                    else                          state_nxt = ST_PAYLOAD;
                end
            end
            ST_PAYLOAD: begin
                if (eot)                                        state_nxt = ST_IDLE;
                else if (pay_take && cnt == wc_q - 16'd1)       state_nxt = ST_FOOTER;
            end
            ST_FOOTER: begin
                if (eot)            state_nxt = ST_IDLE;
                else if (foot_done) state_nxt = ST_DRAIN;
            end
            ST_DRAIN:   if (eot) state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // byte counter and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            wc_q    <= '0;
            hdr_buf <= '0;
            foot_lo <= '0;
        end else begin
            if (state_nxt != state)  cnt <= '0;
            else if (take && in_burst) cnt <= cnt + 16'd1;
            if (state == ST_HEADER && take) begin
                unique case (cnt[1:0])
                    2'd0:    hdr_buf[7:0]   <= in_byte;
                    2'd1:    hdr_buf[15:8]  <= in_byte;
                    2'd2:    hdr_buf[23:16] <= in_byte;
                    default: ;
                endcase
            end
            if (hdr_done)                 wc_q    <= dec_data[23:8];
            if (foot_take && cnt == '0)   foot_lo <= in_byte;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_valid     <= 1'b0;
            hdr_vc        <= '0;
            hdr_dt        <= '0;
            hdr_wc        <= '0;
            hdr_long      <= 1'b0;
            hdr_corrected <= 1'b0;
            hdr_fatal     <= 1'b0;
            pay_valid     <= 1'b0;
            pay_byte      <= '0;
            pay_last      <= 1'b0;
            pkt_end       <= 1'b0;
            crc_err       <= 1'b0;
            trunc_err     <= 1'b0;
        end else begin
            hdr_valid <= hdr_done;
            pay_valid <= pay_take;
            pay_last  <= pay_take && (cnt == wc_q - 16'd1);
            pkt_end   <= foot_done;
            crc_err   <= foot_done && ({in_byte, foot_lo} != crc_cur);
            trunc_err <= eot && in_burst;
            if (pay_take) pay_byte <= in_byte;
            if (hdr_done) begin
                hdr_vc        <= dec_data[7:6];
                hdr_dt        <= dec_data[5:0];
                hdr_wc        <= dec_data[23:8];
                hdr_long      <= dec_long;
                hdr_corrected <= dec_corr;
                hdr_fatal     <= dec_fatal;
            end
        end
    end

    a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pay_last |-> pay_valid);

    a_r5_no_payload_after_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_fatal) |=> !pay_valid);

    a_r3_short_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_long) |=> !pay_valid);

    a_r7_end_alone: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> (!pay_valid && !hdr_valid && !trunc_err));

    a_r4_corr_xor_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> !(hdr_corrected && hdr_fatal));

    a_r9_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> (!pay_valid && !hdr_valid && !pkt_end));

    a_r7_crc_err_with_end: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> pkt_end);

endmodule

// File: tb/test_camrx_pkt_rx.sv
module test_camrx_pkt_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sot = 1'b0, eot = 1'b0, in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        hdr_valid, hdr_long, hdr_corrected, hdr_fatal;
    logic [1:0]  hdr_vc;
    logic [5:0]  hdr_dt;
    logic [15:0] hdr_wc;
    logic        pay_valid, pay_last, pkt_end, crc_err, trunc_err;
    logic [7:0]  pay_byte;

    always #5 clk = ~clk;

    camrx_pkt_rx i_camrx_pkt_rx (
        .clk(clk), .rst_n(rst_n), .sot(sot), .eot(eot), .in_valid(in_valid), .in_byte(in_byte),
        .hdr_valid(hdr_valid), .hdr_vc(hdr_vc), .hdr_dt(hdr_dt), .hdr_wc(hdr_wc),
        .hdr_long(hdr_long), .hdr_corrected(hdr_corrected), .hdr_fatal(hdr_fatal),
        .pay_valid(pay_valid), .pay_byte(pay_byte), .pay_last(pay_last),
        .pkt_end(pkt_end), .crc_err(crc_err), .trunc_err(trunc_err)
    );

    localparam logic [5:0] COLS [24] = '{6'd7, 6'd11, 6'd13, 6'd14, 6'd19, 6'd21, 6'd22, 6'd25,
                                         6'd26, 6'd28, 6'd35, 6'd37, 6'd38, 6'd41, 6'd42, 6'd44,
                                         6'd49, 6'd50, 6'd52, 6'd56, 6'd31, 6'd47, 6'd55, 6'd59};

    int n_cmp = 0, n_bad = 0;
    logic [7:0] pk [0:63];
    logic [7:0] pay_rx [0:63];
    int pay_n, last_n, last_at, end_n, h_n, trunc_n;
    logic crc_seen, h_corr, h_fatal, h_long;
    logic [1:0] h_vc; logic [5:0] h_dt; logic [15:0] h_wc;

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] tb_ecc(logic [23:0] d);
        logic [5:0] p = '0;
        for (int i = 0; i < 24; i++) if (d[i]) p ^= COLS[i];
        return p;
    endfunction

    function automatic logic [15:0] tb_crc(int first, int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++)
            for (int b = 0; b < 8; b++) begin
                logic bit_in = pk[first+k][b] ^ c[0];
                c = {1'b0, c[15:1]} ^ (bit_in ? 16'h8408 : 16'h0000);
            end
        return c;
    endfunction

    function automatic logic [7:0] pay_val(int i);
        return 8'hB8 ^ 8'(i * 37);
    endfunction

    // header into pk[0..3] with bit flips, payload and footer after it; returns total length
    function automatic int build(logic [1:0] vc, logic [5:0] dt, logic [15:0] wc,
                                 logic [31:0] flip, logic [15:0] crc_xor);
        logic [23:0] d = {wc, vc, dt};
        logic [31:0] h = {2'b00, tb_ecc(d), d} ^ flip;
        logic [15:0] c;
        int len = 4;
        for (int k = 0; k < 4; k++) pk[k] = h[k*8 +: 8];
        if (dt >= 6'h10) begin
            for (int i = 0; i < int'(wc); i++) pk[4+i] = pay_val(i);
            c = tb_crc(4, int'(wc)) ^ crc_xor;
            pk[4+int'(wc)] = c[7:0];
            pk[5+int'(wc)] = c[15:8];
            len = 6 + int'(wc);
        end
        return len;
    endfunction

    always @(negedge clk) if (rst_n) begin
        if (hdr_valid) begin
            h_n++; h_vc = hdr_vc; h_dt = hdr_dt; h_wc = hdr_wc;
            h_long = hdr_long; h_corr = hdr_corrected; h_fatal = hdr_fatal;
        end
        if (pay_valid) begin
            if (pay_n < 64) pay_rx[pay_n] = pay_byte;
            if (pay_last) begin last_n++; last_at = pay_n; end
            pay_n++;
        end
        if (pkt_end) begin end_n++; crc_seen = crc_err; end
        if (trunc_err) trunc_n++;
    end

    task automatic clear_mon();
        pay_n = 0; last_n = 0; last_at = -1; end_n = 0; h_n = 0; trunc_n = 0;
        crc_seen = 0; h_corr = 0; h_fatal = 0; h_long = 0; h_vc = 0; h_dt = 0; h_wc = 0;
    endtask

    task automatic send(int n, bit with_eot);
        @(negedge clk) sot = 1'b1;
        @(negedge clk) sot = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_byte = pk[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
        if (with_eot) begin eot = 1'b1; @(negedge clk); eot = 1'b0; end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "hdr_valid", int'(hdr_valid), 0);
        check("R1", "pay_valid", int'(pay_valid), 0);
        check("R1", "pkt_end/crc_err/trunc_err", int'({pkt_end, crc_err, trunc_err, pay_last}), 0);
    endtask

    task automatic t_short();
        int n;
        clear_mon();
        n = build(2'd2, 6'h01, 16'h1234, 32'h0, 16'h0);
        send(n, 1);
        check("R2", "header count", h_n, 1);
        check("R2", "vc", int'(h_vc), 2);
        check("R2", "dt", int'(h_dt), 1);
        check("R2", "short data", int'(h_wc), 16'h1234);
        check("R3", "long flag", int'(h_long), 0);
        check("R3", "payload bytes", pay_n, 0);
        check("R3", "pkt_end count", end_n, 0);
    endtask

    task automatic t_long(int wc, logic [15:0] crc_xor, string req);
        int n;
        clear_mon();
        n = build(2'd1, 6'h2A, 16'(wc), 32'h0, crc_xor);
        send(n, 1);
        check("R3", "long flag", int'(h_long), 1);
        check("R2", "word count", int'(h_wc), wc);
        check("R6", "payload count", pay_n, wc);
        for (int i = 0; i < wc && i < 64; i++)
            check("R6", "payload byte", int'(pay_rx[i]), int'(pay_val(i)));
        check("R6", "last count", last_n, wc > 0 ? 1 : 0);
        if (wc > 0) check("R6", "last index", last_at, wc - 1);
        check(req, "pkt_end count", end_n, 1);
        check(req, "crc_err", int'(crc_seen), crc_xor != 0 ? 1 : 0);
        check("R8", "no truncation", trunc_n, 0);
    endtask

    task automatic t_single(int bitpos);
        int n;
        clear_mon();
        n = build(2'd3, 6'h24, 16'd3, 32'h1 << bitpos, 16'h0);
        send(n, 1);
        check("R4", "corrected flag", int'(h_corr), 1);
        check("R4", "fatal flag", int'(h_fatal), 0);
        check("R4", "vc", int'(h_vc), 3);
        check("R4", "dt", int'(h_dt), 6'h24);
        check("R4", "word count", int'(h_wc), 3);
        check("R4", "payload count", pay_n, 3);
        check("R4", "crc ok", int'(crc_seen), 0);
    endtask

    task automatic t_double();
        int n;
        clear_mon();
        n = build(2'd0, 6'h2B, 16'd4, (32'h1 << 3) | (32'h1 << 17), 16'h0);
        send(n, 1);
        check("R5", "fatal flag", int'(h_fatal), 1);
        check("R5", "payload count", pay_n, 0);
        check("R5", "pkt_end count", end_n, 0);
        check("R5", "truncation", trunc_n, 0);
    endtask

    task automatic t_trunc();
        int n;
        clear_mon();
        n = build(2'd1, 6'h2A, 16'd6, 32'h0, 16'h0);
        send(7, 1);
        check("R8", "trunc count", trunc_n, 1);
        check("R8", "pkt_end count", end_n, 0);
        check("R8", "payload count", pay_n, 3);
        clear_mon();
        n = build(2'd2, 6'h03, 16'h00A5, 32'h0, 16'h0);
        send(n, 1);
        check("R8", "idle after truncation, header", h_n, 1);
        check("R8", "short data after truncation", int'(h_wc), 16'h00A5);
    endtask

    task automatic t_extra();
        int n;
        clear_mon();
        n = build(2'd0, 6'h1E, 16'd2, 32'h0, 16'h0);
        for (int i = 0; i < 5; i++) pk[n+i] = 8'(8'h40 + i);
        send(n + 5, 1);
        check("R9", "payload count with trailing bytes", pay_n, 2);
        check("R9", "header count", h_n, 1);
        check("R9", "pkt_end count", end_n, 1);
        check("R9", "no truncation", trunc_n, 0);
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_short();
        t_long(5, 16'h0000, "R7");
        t_long(5, 16'h0100, "R7");
        t_long(0, 16'h0000, "R10");
        t_long(1, 16'h0001, "R10");
        t_single(13);
        t_single(0);
        t_single(26);
        t_double();
        t_trunc();
        t_extra();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule